// File: doc/BRIEF.md
# Load-and-Match Interval Timer

This block is a one-shot interval timer attached to a simple on-chip user bus. The bus carries a chip select held for two clock cycles, a read/write flag, a 16-bit byte address, four byte-lane enables and 32-bit write and read data. Software writes a 32-bit target value into the block's target register. That write clears a free-running 32-bit up-counter to zero and starts it. The counter advances once per clock until it equals the target. It then stops and holds that value.

When the counter stops, the block raises an active-high, level-sensitive interrupt. The interrupt stays high until a single-cycle acknowledge pulse arrives on its own input, or until a new target is loaded. A new load always clears a pending interrupt and restarts the count from zero. Software can read back the target, the live count and a flag word. The flag word reports whether an interrupt is pending and whether the counter is still running. After reset the block sits idle until the first load.

Top module: `tmr_interval`

## Requirements
- R1: After reset the interrupt is low and the target, count and flag words all read zero. With no load, the interrupt stays low and the count stays zero.
- R2: The target register sits at window offset 0x0. A write there merges the write data into the target lane by lane: enable bit i covers data bits 8i+7..8i. The write clears the count to zero and starts counting. It acts once for each chip-select assertion, even though chip select is held two cycles.
- R3: While running, the count rises by exactly one per clock. On reaching the target it stops and holds that value.
- R4: With target N loaded on clock edge L, the interrupt first reads high after edge L+N+1. It is low after every earlier edge. A target of zero raises it on the very next edge.
- R5: A pending interrupt stays high until the acknowledge input is sampled high. An acknowledge with nothing pending has no effect. When an acknowledge and a match fall on the same edge, the interrupt ends up high.
- R6: A load that arrives while the interrupt is pending clears the interrupt on the load edge and restarts the count from zero.
- R7: Reads return the target at offset 0x0, the count at 0x4 and the flag word at 0x8. In the flag word, bit 0 is interrupt pending and bit 1 is running. Offset 0xC reads zero. Read data is valid during the second chip-select cycle and is zero whenever chip select is low.
- R8: The block ignores a write that misses the 16-byte window at BASE_ADDR, a write to any offset other than 0x0, and a write with all byte enables low. Such a write leaves the target, count and interrupt untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Chip select, held two cycles per access |
| bus_rnw | input | 1 | 1 = read, 0 = write; valid with bus_cs |
| bus_addr | input | 16 | Byte address of the access |
| bus_be | input | 4 | Byte-lane enables; bit i covers data bits 8i+7..8i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the second chip-select cycle |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| irq | output | 1 | Level interrupt, active high |

## Verification
Two pairs of functions can collide on one clock edge. The first pair is the acknowledge pulse and the match that sets the interrupt. The bench provokes this by loading a target of five and raising the acknowledge so that it is sampled on the same edge as the match. It then requires the interrupt to read high. The second pair is a load and a pending interrupt. The bench loads a new target while the interrupt is high, requires the interrupt to read low right after the load edge, and requires it to rise again exactly N+1 edges later. A sweep over targets 0 to 20 fixes the rise edge of the interrupt for each target, and read-backs of the count confirm the held value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // register selector taken from the word-offset bits of the address
    typedef enum logic [1:0] {
        SEL_TARGET = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_FLAGS  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // bit positions inside the flag word
    localparam int unsigned FLAG_PEND_BIT = 0;
    localparam int unsigned FLAG_RUN_BIT  = 1;

endpackage

// File: rtl/tmr_lane_merge.sv
module tmr_lane_merge #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]   old_i,
    input  logic [DATA_W-1:0]   new_i,
    input  logic [DATA_W/8-1:0] lane_en_i,
    output logic [DATA_W-1:0]   merged_o
);

    localparam int unsigned LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged_o[8*g +: 8] = lane_en_i[g] ? new_i[8*g +: 8] : old_i[8*g +: 8];
    end

endmodule

// File: rtl/tmr_bus_port.sv
module tmr_bus_port
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0040
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_i,
    input  logic                rnw_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W/8-1:0] be_i,
    input  logic [DATA_W-1:0]   target_i,
    input  logic [DATA_W-1:0]   count_i,
    input  logic                pend_i,
    input  logic                run_i,
    output logic                load_o,
    output logic [DATA_W-1:0]   rdata_o
);

    localparam int unsigned WORD_LSB = $clog2(DATA_W / 8);
    localparam int unsigned OFS_W    = WORD_LSB + 2;

    typedef struct packed {
        logic              cs_seen;
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;

    logic              first_cyc;
    logic              win_hit;
    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] flag_word;
    logic              addr_lsb_unused;

    assign addr_lsb_unused = ^addr_i[WORD_LSB-1:0];

    always_comb begin
        flag_word                = '0;
        flag_word[FLAG_PEND_BIT] = pend_i;
        flag_word[FLAG_RUN_BIT]  = run_i;
    end

    always_comb begin
        first_cyc = cs_i && !st_q.cs_seen;
        win_hit   = (addr_i[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
        sel       = reg_sel_e'(addr_i[OFS_W-1:WORD_LSB]);

        unique case (sel)
            SEL_TARGET: rd_mux = target_i;
            SEL_COUNT:  rd_mux = count_i;
            SEL_FLAGS:  rd_mux = flag_word;
            default:    rd_mux = '0;
        endcase

        load_o = first_cyc && win_hit && !rnw_i && (sel == SEL_TARGET) && (|be_i);

        st_d         = st_q;
        st_d.cs_seen = cs_i;
        if (first_cyc && rnw_i) begin
            st_d.rdata = win_hit ? rd_mux : '0;
        end else if (!cs_i) begin
            st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] target_o,
    output logic             run_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] target;
        logic             running;
        logic             irq;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        st_d = st_q;
        hit  = st_q.running && (st_q.count == st_q.target);

        // acknowledge first, so that a match on the same edge wins
        if (ack_i) begin
            st_d.irq = 1'b0;
        end
        if (st_q.running) begin
            if (hit) begin
                st_d.running = 1'b0;
                st_d.irq     = 1'b1;
            end else begin
                st_d.count = st_q.count + CNT_W'(1);
            end
        end
        // a load overrides everything else
        if (load_i) begin
            st_d.target  = load_val_i;
            st_d.count   = '0;
            st_d.running = 1'b1;
            st_d.irq     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.count;
    assign target_o = st_q.target;
    assign run_o    = st_q.running;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/tmr_interval.sv
module tmr_interval #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0040
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_cs,
    input  logic                bus_rnw,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                irq_ack,
    output logic                irq
);

    localparam int unsigned LANES = DATA_W / 8;

    logic              load_w;
    logic [DATA_W-1:0] merged_w;
    logic [DATA_W-1:0] cnt_w;
    logic [DATA_W-1:0] tgt_w;
    logic              run_w;
    logic              irq_w;

    tmr_bus_port #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_port (
        .clk     (clk),
        .rst     (rst),
        .cs_i    (bus_cs),
        .rnw_i   (bus_rnw),
        .addr_i  (bus_addr),
        .be_i    (bus_be),
        .target_i(tgt_w),
        .count_i (cnt_w),
        .pend_i  (irq_w),
        .run_i   (run_w),
        .load_o  (load_w),
        .rdata_o (bus_rdata)
    );

    tmr_lane_merge #(
        .DATA_W(DATA_W)
    ) u_merge (
        .old_i    (tgt_w),
        .new_i    (bus_wdata),
        .lane_en_i(bus_be[LANES-1:0]),
        .merged_o (merged_w)
    );

    tmr_core #(
        .CNT_W(DATA_W)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_w),
        .load_val_i(merged_w),
        .ack_i     (irq_ack),
        .count_o   (cnt_w),
        .target_o  (tgt_w),
        .run_o     (run_w),
        .irq_o     (irq_w)
    );

    assign irq = irq_w;

endmodule

// File: rtl/tmr_interval_chk.sv
module tmr_interval_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cs,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_ack,
    input logic              irq,
    input logic              load_w,
    input logic              run_w,
    input logic [DATA_W-1:0] cnt_w,
    input logic [DATA_W-1:0] tgt_w
);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_w && (cnt_w != tgt_w) && !load_w) |=> (cnt_w == $past(cnt_w) + DATA_W'(1)));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_w && !load_w) |=> $stable(cnt_w));

    // R4
    match_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (run_w && (cnt_w == tgt_w) && !load_w) |=> (irq && !run_w));

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack && !load_w) |=> irq);

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && irq_ack && !load_w && !(run_w && (cnt_w == tgt_w))) |=> !irq);

    // R6
    load_restart_chk: assert property (@(posedge clk) disable iff (rst)
        load_w |=> (!irq && run_w && (cnt_w == '0)));

    // R7
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_cs |=> (bus_rdata == '0));

endmodule

bind tmr_interval tmr_interval_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_cs   (bus_cs),
    .bus_rdata(bus_rdata),
    .irq_ack  (irq_ack),
    .irq      (irq),
    .load_w   (load_w),
    .run_w    (run_w),
    .cnt_w    (cnt_w),
    .tgt_w    (tgt_w)
);

// File: tb/tmr_interval_test.sv
`timescale 1ns/1ps
module tmr_interval_test;

    localparam logic [15:0] BASE = 16'h0040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs = 1'b0;
    logic        bus_rnw = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_ack = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    tmr_interval uut (
        .clk      (clk),
        .rst      (rst),
        .bus_cs   (bus_cs),
        .bus_rnw  (bus_rnw),
        .bus_addr (bus_addr),
        .bus_be   (bus_be),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_ack  (irq_ack),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // returns on the falling edge one edge after the load edge
    task automatic bus_wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_rnw = 1'b0; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        @(negedge clk);
        bus_cs = 1'b0; bus_rnw = 1'b1; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_rnw = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(negedge clk);
        bus_cs = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #800000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] c1;
        logic [31:0] c2;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state and idle
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R7 rdata idle", bus_rdata, 32'd0);
        repeat (8) @(negedge clk);
        chk("R1 irq idle", {31'd0, irq}, 32'd0);
        bus_rd(BASE + 16'h0, rd); chk("R1 target", rd, 32'd0);
        bus_rd(BASE + 16'h4, rd); chk("R1 count", rd, 32'd0);
        bus_rd(BASE + 16'h8, rd); chk("R1 flags", rd, 32'd0);

        // R4 / R3 sweep over targets
        for (int n = 0; n <= 20; n++) begin
            bus_wr(BASE, 4'hF, n);
            for (int e = 1; e <= n + 2; e++) begin
                chk("R4 irq timing", {31'd0, irq}, (e >= n + 1) ? 32'd1 : 32'd0);
                @(negedge clk);
            end
            bus_rd(BASE + 16'h4, rd); chk("R3 held count", rd, n);
            bus_rd(BASE + 16'h8, rd); chk("R7 flags pending", rd, 32'd1);
            bus_rd(BASE + 16'h0, rd); chk("R7 target read", rd, n);
            pulse_ack();
            chk("R5 ack clears", {31'd0, irq}, 32'd0);
        end

        // R5 hold until ack, ack without pending ignored
        bus_wr(BASE, 4'hF, 32'd1);
        repeat (12) @(negedge clk);
        chk("R5 irq held", {31'd0, irq}, 32'd1);
        pulse_ack();
        pulse_ack();
        chk("R5 ack idle no effect", {31'd0, irq}, 32'd0);
        bus_rd(BASE + 16'h8, rd); chk("R5 flags after idle ack", rd, 32'd0);
        bus_rd(BASE + 16'h4, rd); chk("R5 count after idle ack", rd, 32'd1);

        // R5 ack on the same edge as the match
        bus_wr(BASE, 4'hF, 32'd5);
        repeat (4) @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R5 match beats ack", {31'd0, irq}, 32'd1);

        // R6 load while pending
        bus_wr(BASE, 4'hF, 32'd3);
        chk("R6 load clears irq", {31'd0, irq}, 32'd0);
        for (int e = 2; e <= 5; e++) begin
            @(negedge clk);
            chk("R6 restart timing", {31'd0, irq}, (e >= 4) ? 32'd1 : 32'd0);
        end

        // R3 running count and running flag
        bus_wr(BASE, 4'hF, 32'd1000);
        chk("R6 irq cleared by long load", {31'd0, irq}, 32'd0);
        bus_rd(BASE + 16'h8, rd); chk("R7 flags running", rd, 32'd2);
        bus_rd(BASE + 16'h4, c1);
        bus_rd(BASE + 16'h4, c2);
        chk("R3 count rate", c2 - c1, 32'd3);

        // R2 byte-lane merge
        bus_wr(BASE, 4'hF, 32'h11223344);
        bus_rd(BASE, rd); chk("R2 full write", rd, 32'h11223344);
        bus_wr(BASE, 4'b0001, 32'hFFFFFFAA);
        bus_rd(BASE, rd); chk("R2 lane0 write", rd, 32'h112233AA);
        bus_wr(BASE, 4'b1000, 32'h55FFFFFF);
        bus_rd(BASE, rd); chk("R2 lane3 write", rd, 32'h552233AA);
        bus_wr(BASE, 4'b0110, 32'hFF6677FF);
        bus_rd(BASE, rd); chk("R2 middle lanes", rd, 32'h556677AA);

        // R8 ignored writes while pending
        bus_wr(BASE, 4'hF, 32'd0);
        chk("R2 zero target next edge", {31'd0, irq}, 32'd1);
        bus_wr(BASE + 16'h0100, 4'hF, 32'd7);
        chk("R8 window miss irq", {31'd0, irq}, 32'd1);
        bus_wr(BASE + 16'h4, 4'hF, 32'd9);
        chk("R8 count offset irq", {31'd0, irq}, 32'd1);
        bus_wr(BASE + 16'h8, 4'hF, 32'd9);
        bus_wr(BASE, 4'h0, 32'd9);
        chk("R8 no lanes irq", {31'd0, irq}, 32'd1);
        bus_rd(BASE, rd); chk("R8 target unchanged", rd, 32'd0);
        bus_rd(BASE + 16'h4, rd); chk("R8 count unchanged", rd, 32'd0);
        bus_rd(BASE + 16'hC, rd); chk("R7 unused offset", rd, 32'd0);
        bus_rd(BASE + 16'h0100, rd); chk("R7 window miss read", rd, 32'd0);
        @(negedge clk);
        chk("R7 rdata after read", bus_rdata, 32'd0);

        // R1 reset mid-run
        bus_wr(BASE, 4'hF, 32'd1000);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        bus_rd(BASE + 16'h8, rd); chk("R1 flags after reset", rd, 32'd0);
        bus_rd(BASE + 16'h4, rd); chk("R1 count after reset", rd, 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule